// File: doc/BRIEF.md
# Bulk-Configurable 32-Pin GPIO Port

This block is a general-purpose I/O port controller for 32 pads behind a simple word-addressed register bus. Software sets each pin's drive state through a direction register and an output-level register. Both can be written whole or changed bit by bit through alias addresses. The set and clear aliases, and the toggle alias of the output register, touch only the bits that are 1 in the written word. This lets separate pieces of software share a port without read-modify-write races.

Every pin also holds a three-bit configuration: input enable, pull enable and peripheral-mux enable. It also holds a 4-bit selector that picks one of 16 peripheral signals to drive the pad when the mux is enabled. Two neighbouring pins share one selector word. A single write to the bulk configuration register can apply one configuration value to any subset of 16 pins in either half of the port. The pad-side outputs (level, drive enable, pull enable, pull direction) are registered. Pad inputs pass through a two-stage synchronizer before they can be read.

Top module: `gpio_bulk_port`

## Requirements
- R1: A synchronous active-high reset clears direction, output level, every pin configuration, every selector, the synchronizers, the read data and all pad outputs to 0.
- R2: Direction is written whole at offset 0x00. Writing offset 0x08 sets the masked bits (those pins become outputs), and writing offset 0x04 clears them (those pins become inputs). The other bits keep their values. Both aliases read back the direction value.
- R3: Output level is written whole at 0x10. Offsets 0x14, 0x18 and 0x1C clear, set and invert only the bits that are 1 in the written word. All four read back the output value.
- R4: A write to the bulk register at 0x24 with strobe bit 24 set and half bit 31 at 0 copies bits 18:16 (mux enable, pull enable, input enable) into the configuration of each pin 0–15 whose bit is 1 in mask bits 15:0. Unmasked pins and pins 16–31 are unchanged.
- R5: The same write with half bit 31 at 1 applies mask bit n to pin 16+n and leaves pins 0–15 unchanged.
- R6: A bulk write with strobe bit 24 at 0 changes no pin configuration. The bulk register always reads 0.
- R7: Pad pull enable for a pin is 1 exactly when its pull enable bit is 1, its direction is input and its mux enable is 0. Pad pull direction is then the pin's output-level bit (1 = up, 0 = down), and it is 0 when the pull is inactive.
- R8: Pin n's configuration reads and writes at 0x80+4n in bits 2:0 (bit 0 input enable, bit 1 pull enable, bit 2 mux enable). Selector word k at 0x40+4k holds pin 2k's selector in bits 3:0 and pin 2k+1's in bits 7:4. A pin with mux enable 1 drives pad level and drive enable from the peripheral level and enable inputs at the index given by its selector.
- R9: A pin with mux enable 0 is under GPIO control whatever its selector holds. Its pad level and drive enable follow the output-level and direction bits.
- R10: Offset 0x20 reads each pad through two synchronizing flops. A pin whose input enable is 0 reads 0. A pad change is visible in read data on the third clock edge after it occurs.
- R11: Pad outputs are registered. A register write shows at the pads one clock edge after the edge that performs the write. Read data is registered and valid one edge after the address is presented.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe for the current address |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | 32 | Raw pad input levels |
| periph_out | input | 16 | Peripheral output levels, selectable per pin |
| periph_oe | input | 16 | Peripheral drive enables, selectable per pin |
| pad_out | output | 32 | Pad output level |
| pad_oe | output | 32 | Pad drive enable |
| pad_pull_en | output | 32 | Pad pull resistor enable |
| pad_pull_up | output | 32 | Pad pull direction, 1 = up |

## Verification
The bench targets the half-select boundary: a design that ignored bit 31 would write the low pins twice and never reach pins 16 and 31. It also issues a bulk write with every mask bit set but no strobe; a design that ignored the strobe would overwrite pin 0's configuration. It checks that selector nibbles land on the right pin of a pair and that disabling the mux hands a pin back to its GPIO registers while the peripheral line is still high; swapped nibbles or a sticky mux would drive the wrong level. Finally, it samples the input register on the second and third edges after a pad change. This exposes a missing or extra synchronizer stage, and also a disabled pin that leaks its pad value.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  typedef struct packed {
    logic mux_en;
    logic pull_en;
    logic in_en;
  } pin_cfg_t;

  localparam int OFF_DIR     = 'h00;
  localparam int OFF_DIR_CLR = 'h04;
  localparam int OFF_DIR_SET = 'h08;
  localparam int OFF_OUT     = 'h10;
  localparam int OFF_OUT_CLR = 'h14;
  localparam int OFF_OUT_SET = 'h18;
  localparam int OFF_OUT_TGL = 'h1C;
  localparam int OFF_IN      = 'h20;
  localparam int OFF_BULK    = 'h24;

  localparam int BULK_CFG_LO = 16;
  localparam int BULK_STROBE = 24;
  localparam int BULK_HALF   = 31;

  localparam int SEL_W = 4;

endpackage

// File: rtl/gpio_cfg_bank.sv
module gpio_cfg_bank
  import gpio_port_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             cfg_we,
  input  logic [$clog2(NPINS)-1:0]         cfg_idx,
  input  pin_cfg_t                         cfg_wdata,
  input  logic                             sel_we,
  input  logic [$clog2(NPINS)-2:0]         sel_idx,
  input  logic [2*SEL_W-1:0]               sel_wdata,
  input  logic                             bulk_we,
  input  logic                             bulk_strobe,
  input  logic                             bulk_half,
  input  logic [NPINS/2-1:0]               bulk_mask,
  input  pin_cfg_t                         bulk_cfg,
  output pin_cfg_t [NPINS-1:0]             cfg_q,
  output logic [NPINS-1:0][SEL_W-1:0]      sel_q
);

  localparam int HALFW  = NPINS / 2;
  localparam int IDX_W  = $clog2(NPINS);
  localparam int PAIR_W = IDX_W - 1;

  logic bulk_go;
  assign bulk_go = bulk_we && bulk_strobe;

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    localparam bit UPPER = (i >= HALFW);
    pin_cfg_t          c_q;
    logic [SEL_W-1:0]  s_q;
    logic              direct_hit;
    logic              bulk_hit;
    logic              sel_hit;
    logic [SEL_W-1:0]  sel_nib;

    assign direct_hit = cfg_we && (cfg_idx == IDX_W'(i));
    assign bulk_hit   = bulk_go && (bulk_half == UPPER) && bulk_mask[i % HALFW];
    assign sel_hit    = sel_we && (sel_idx == PAIR_W'(i / 2));

    if (i % 2 == 1) begin : g_odd
      assign sel_nib = sel_wdata[2*SEL_W-1:SEL_W];
    end else begin : g_even
      assign sel_nib = sel_wdata[SEL_W-1:0];
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        c_q <= '0;
      end else if (direct_hit) begin
        c_q <= cfg_wdata;
      end else if (bulk_hit) begin
        c_q <= bulk_cfg;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        s_q <= '0;
      end else if (sel_hit) begin
        s_q <= sel_nib;
      end
    end

    assign cfg_q[i] = c_q;
    assign sel_q[i] = s_q;
  end

  AST_BULK_HOLD: assert property (@(posedge clk) disable iff (rst)
    (bulk_we && !bulk_strobe && !cfg_we) |=> $stable(cfg_q)); // R6

  AST_LOW_HALF_KEEPS_UPPER: assert property (@(posedge clk) disable iff (rst)
    (bulk_go && !bulk_half && !cfg_we) |=> $stable(cfg_q[NPINS-1:HALFW])); // R4

  AST_HIGH_HALF_KEEPS_LOWER: assert property (@(posedge clk) disable iff (rst)
    (bulk_go && bulk_half && !cfg_we) |=> $stable(cfg_q[HALFW-1:0])); // R5

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] pad_in,
  input  logic [NPINS-1:0] in_en,
  output logic [NPINS-1:0] in_val
);

  logic [NPINS-1:0] meta_q;
  logic [NPINS-1:0] stable_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q   <= '0;
      stable_q <= '0;
    end else begin
      meta_q   <= pad_in;
      stable_q <= meta_q;
    end
  end

  assign in_val = stable_q & in_en;

endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive
  import gpio_port_pkg::*;
#(
  parameter int NPINS   = 32,
  parameter int NPERIPH = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NPINS-1:0]             dir,
  input  logic [NPINS-1:0]             lvl,
  input  pin_cfg_t [NPINS-1:0]         cfg,
  input  logic [NPINS-1:0][SEL_W-1:0]  sel,
  input  logic [NPERIPH-1:0]           periph_out,
  input  logic [NPERIPH-1:0]           periph_oe,
  output logic [NPINS-1:0]             pad_out,
  output logic [NPINS-1:0]             pad_oe,
  output logic [NPINS-1:0]             pad_pull_en,
  output logic [NPINS-1:0]             pad_pull_up
);

  localparam int NSRC = 1 << SEL_W;

  logic [NSRC-1:0] src_lvl;
  logic [NSRC-1:0] src_oe;

  assign src_lvl = NSRC'(periph_out);
  assign src_oe  = NSRC'(periph_oe);

  for (genvar i = 0; i < NPINS; i++) begin : g_pad
    logic out_d, oe_d, pull_d;
    logic out_q, oe_q, pull_q, up_q;

    always_comb begin
      if (cfg[i].mux_en) begin
        out_d = src_lvl[sel[i]];
        oe_d  = src_oe[sel[i]];
      end else begin
        out_d = lvl[i];
        oe_d  = dir[i];
      end
      pull_d = cfg[i].pull_en && !dir[i] && !cfg[i].mux_en;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        out_q  <= 1'b0;
        oe_q   <= 1'b0;
        pull_q <= 1'b0;
        up_q   <= 1'b0;
      end else begin
        out_q  <= out_d;
        oe_q   <= oe_d;
        pull_q <= pull_d;
        up_q   <= pull_d && lvl[i];
      end
    end

    assign pad_out[i]     = out_q;
    assign pad_oe[i]      = oe_q;
    assign pad_pull_en[i] = pull_q;
    assign pad_pull_up[i] = up_q;

    AST_PULL_NOT_DRIVING: assert property (@(posedge clk) disable iff (rst)
      pad_pull_en[i] |-> !pad_oe[i]); // R7

    AST_PERIPH_FOLLOW: assert property (@(posedge clk) disable iff (rst)
      cfg[i].mux_en |=> (pad_out[i] == $past(src_lvl[sel[i]]))); // R8

    AST_GPIO_OWNS_PIN: assert property (@(posedge clk) disable iff (rst)
      !cfg[i].mux_en |=> (pad_oe[i] == $past(dir[i]) && pad_out[i] == $past(lvl[i]))); // R9
  end

endmodule

// File: rtl/gpio_bulk_port.sv
module gpio_bulk_port
  import gpio_port_pkg::*;
#(
  parameter int NPINS   = 32,
  parameter int NPERIPH = 16,
  parameter int AW      = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_we,
  input  logic [AW-1:0]      bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic [NPINS-1:0]   pad_in,
  input  logic [NPERIPH-1:0] periph_out,
  input  logic [NPERIPH-1:0] periph_oe,
  output logic [NPINS-1:0]   pad_out,
  output logic [NPINS-1:0]   pad_oe,
  output logic [NPINS-1:0]   pad_pull_en,
  output logic [NPINS-1:0]   pad_pull_up
);

  localparam int HALFW  = NPINS / 2;
  localparam int IDX_W  = $clog2(NPINS);
  localparam int PAIR_W = IDX_W - 1;

  logic [NPINS-1:0]            dir_q;
  logic [NPINS-1:0]            lvl_q;
  logic [NPINS-1:0]            in_val;
  logic [NPINS-1:0]            in_en_vec;
  pin_cfg_t [NPINS-1:0]        cfg_q;
  logic [NPINS-1:0][SEL_W-1:0] sel_q;

  logic               cfg_hit, sel_hit, bulk_hit;
  logic [IDX_W-1:0]   pin_idx;
  logic [PAIR_W-1:0]  pair_idx;
  logic [NPINS-1:0]   wmask;
  logic [31:0]        rd_d;

  assign wmask    = bus_wdata[NPINS-1:0];
  assign pin_idx  = bus_addr[IDX_W+1:2];
  assign pair_idx = bus_addr[PAIR_W+1:2];
  assign cfg_hit  = (bus_addr >> (IDX_W + 2)) == AW'(1);
  assign sel_hit  = (bus_addr >> (IDX_W + 1)) == AW'(1);
  assign bulk_hit = (bus_addr == AW'(OFF_BULK));

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= '0;
      lvl_q <= '0;
    end else if (bus_we) begin
      case (bus_addr)
        AW'(OFF_DIR):     dir_q <= wmask;
        AW'(OFF_DIR_CLR): dir_q <= dir_q & ~wmask;
        AW'(OFF_DIR_SET): dir_q <= dir_q | wmask;
        AW'(OFF_OUT):     lvl_q <= wmask;
        AW'(OFF_OUT_CLR): lvl_q <= lvl_q & ~wmask;
        AW'(OFF_OUT_SET): lvl_q <= lvl_q | wmask;
        AW'(OFF_OUT_TGL): lvl_q <= lvl_q ^ wmask;
        default: ;
      endcase
    end
  end

  gpio_cfg_bank #(.NPINS(NPINS)) u_cfg (
    .clk         (clk),
    .rst         (rst),
    .cfg_we      (bus_we && cfg_hit),
    .cfg_idx     (pin_idx),
    .cfg_wdata   (pin_cfg_t'(bus_wdata[2:0])),
    .sel_we      (bus_we && sel_hit),
    .sel_idx     (pair_idx),
    .sel_wdata   (bus_wdata[2*SEL_W-1:0]),
    .bulk_we     (bus_we && bulk_hit),
    .bulk_strobe (bus_wdata[BULK_STROBE]),
    .bulk_half   (bus_wdata[BULK_HALF]),
    .bulk_mask   (bus_wdata[HALFW-1:0]),
    .bulk_cfg    (pin_cfg_t'(bus_wdata[BULK_CFG_LO+2:BULK_CFG_LO])),
    .cfg_q       (cfg_q),
    .sel_q       (sel_q)
  );

  for (genvar i = 0; i < NPINS; i++) begin : g_inen
    assign in_en_vec[i] = cfg_q[i].in_en;
  end

  gpio_in_sync #(.NPINS(NPINS)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .pad_in (pad_in),
    .in_en  (in_en_vec),
    .in_val (in_val)
  );

  gpio_pad_drive #(.NPINS(NPINS), .NPERIPH(NPERIPH)) u_pad (
    .clk         (clk),
    .rst         (rst),
    .dir         (dir_q),
    .lvl         (lvl_q),
    .cfg         (cfg_q),
    .sel         (sel_q),
    .periph_out  (periph_out),
    .periph_oe   (periph_oe),
    .pad_out     (pad_out),
    .pad_oe      (pad_oe),
    .pad_pull_en (pad_pull_en),
    .pad_pull_up (pad_pull_up)
  );

  always_comb begin
    rd_d = '0;
    if (bus_addr == AW'(OFF_DIR) || bus_addr == AW'(OFF_DIR_CLR) ||
        bus_addr == AW'(OFF_DIR_SET)) begin
      rd_d = 32'(dir_q);
    end else if (bus_addr == AW'(OFF_OUT) || bus_addr == AW'(OFF_OUT_CLR) ||
                 bus_addr == AW'(OFF_OUT_SET) || bus_addr == AW'(OFF_OUT_TGL)) begin
      rd_d = 32'(lvl_q);
    end else if (bus_addr == AW'(OFF_IN)) begin
      rd_d = 32'(in_val);
    end else if (cfg_hit) begin
      rd_d = 32'(cfg_q[pin_idx]);
    end else if (sel_hit) begin
      rd_d = 32'({sel_q[{pair_idx, 1'b1}], sel_q[{pair_idx, 1'b0}]});
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_d;
  end

  AST_DIR_SET_MASKED: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == AW'(OFF_DIR_SET)) |=>
      (dir_q == ($past(dir_q) | $past(wmask)))); // R2

  AST_DIR_CLR_MASKED: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == AW'(OFF_DIR_CLR)) |=>
      (dir_q == ($past(dir_q) & ~$past(wmask)))); // R2

  AST_OUT_TGL_MASKED: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == AW'(OFF_OUT_TGL)) |=>
      (lvl_q == ($past(lvl_q) ^ $past(wmask)))); // R3

  AST_IN_GATED: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == AW'(OFF_IN)) |=>
      ((bus_rdata[NPINS-1:0] & ~$past(in_en_vec)) == '0)); // R10

  AST_BULK_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    bulk_hit |=> (bus_rdata == '0)); // R6

endmodule

// File: tb/gpio_bulk_port_test.sv
`timescale 1ns/1ps
module gpio_bulk_port_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pad_in = '0;
  logic [15:0] periph_out = '0;
  logic [15:0] periph_oe = '0;
  logic [31:0] pad_out, pad_oe, pad_pull_en, pad_pull_up;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  gpio_bulk_port uut (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .periph_out(periph_out), .periph_oe(periph_oe), .pad_out(pad_out),
    .pad_oe(pad_oe), .pad_pull_en(pad_pull_en), .pad_pull_up(pad_pull_up)
  );

  typedef struct packed {
    logic        wen;
    logic [7:0]  waddr;
    logic [31:0] wdata;
    logic [7:0]  raddr;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 8'h00, 32'h000000FF, 8'h00, 32'h000000FF, 4'd2},  // R2 whole write
    '{1'b1, 8'h08, 32'hF0000000, 8'h00, 32'hF00000FF, 4'd2},  // R2 set alias
    '{1'b1, 8'h04, 32'h0000000F, 8'h00, 32'hF00000F0, 4'd2},  // R2 clear alias
    '{1'b1, 8'h10, 32'h12345678, 8'h10, 32'h12345678, 4'd3},  // R3 whole write
    '{1'b1, 8'h18, 32'h80000001, 8'h10, 32'h92345679, 4'd3},  // R3 set
    '{1'b1, 8'h14, 32'h00000070, 8'h10, 32'h92345609, 4'd3},  // R3 clear
    '{1'b1, 8'h1C, 32'hFFFF0000, 8'h10, 32'h6DCB5609, 4'd3},  // R3 toggle
    '{1'b1, 8'h24, 32'h01010005, 8'h80, 32'h00000001, 4'd4},  // R4 pin0 gets in_en
    '{1'b0, 8'h00, 32'h0,        8'h88, 32'h00000001, 4'd4},  // R4 pin2 gets in_en
    '{1'b0, 8'h00, 32'h0,        8'h84, 32'h00000000, 4'd4},  // R4 pin1 unmasked
    '{1'b1, 8'h24, 32'h81028001, 8'hC0, 32'h00000002, 4'd5},  // R5 pin16 pull
    '{1'b0, 8'h00, 32'h0,        8'hFC, 32'h00000002, 4'd5},  // R5 pin31 pull
    '{1'b0, 8'h00, 32'h0,        8'h80, 32'h00000001, 4'd5},  // R5 lower half kept
    '{1'b1, 8'h24, 32'h0007FFFF, 8'h80, 32'h00000001, 4'd6},  // R6 no strobe
    '{1'b0, 8'h00, 32'h0,        8'h24, 32'h00000000, 4'd6},  // R6 reads zero
    '{1'b1, 8'h94, 32'h00000004, 8'h94, 32'h00000004, 4'd8},  // R8 pin5 cfg
    '{1'b1, 8'h48, 32'h000000A3, 8'h48, 32'h000000A3, 4'd8}   // R8 selector pair 2
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] q);
    bus_addr = a;
    @(posedge clk); #1;
    q = bus_rdata;
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] q;
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    // R1 reset state
    rd(8'h00, q);  chk("R1", q, 32'h0);
    rd(8'h80, q);  chk("R1", q, 32'h0);
    chk("R1", pad_oe, 32'h0);
    chk("R1", pad_pull_en, 32'h0);
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].wen) wr(VECS[i].waddr, VECS[i].wdata);
      rd(VECS[i].raddr, q);
      chk($sformatf("R%0d vec%0d", VECS[i].req, i), q, VECS[i].exp);
      @(negedge clk);
    end

    // R11 pad outputs follow registers one edge later (pin5 muxed, pin4 not yet)
    tick();
    chk("R11", pad_oe & ~32'h20, 32'hF00000D0);
    chk("R11", pad_out & ~32'h20, 32'h6DCB5609 & ~32'h20);
    @(negedge clk);

    // R8 pin4 selector 3 (low nibble), pin5 selector 10 (high nibble)
    wr(8'h90, 32'h4);
    periph_out = 16'h0408; periph_oe = 16'h0000;
    tick();
    chk("R8", {30'h0, pad_out[5:4]}, 32'h3);
    chk("R8", {30'h0, pad_oe[5:4]}, 32'h0);
    periph_out = 16'h0008; periph_oe = 16'h0400;
    tick();
    chk("R8", {30'h0, pad_out[5:4]}, 32'h1);
    chk("R8", {30'h0, pad_oe[5:4]}, 32'h2);
    @(negedge clk);

    // R9 clearing mux enable returns pin5 to GPIO, selector still 10
    wr(8'h94, 32'h0);
    periph_out = 16'h0400; periph_oe = 16'h0000;
    tick();
    chk("R9", {31'h0, pad_out[5]}, 32'h0);
    chk("R9", {31'h0, pad_oe[5]}, 32'h1);
    rd(8'h48, q); chk("R9", q, 32'h000000A3);
    @(negedge clk);

    // R7 pull on pin16 (input, level 1) and none on pin31 (output)
    chk("R7", pad_pull_en, 32'h00010000);
    chk("R7", pad_pull_up, 32'h00010000);
    wr(8'h14, 32'h00010000);
    tick();
    chk("R7", pad_pull_up, 32'h0);
    chk("R7", pad_pull_en, 32'h00010000);
    @(negedge clk);
    wr(8'h08, 32'h00010000);
    tick();
    chk("R7", pad_pull_en, 32'h0);
    @(negedge clk);

    // R10 input path: pins 0 and 2 enabled, pin 1 not
    bus_addr = 8'h20;
    tick();
    chk("R10", bus_rdata, 32'h0);
    pad_in = 32'h8000_0007;
    tick(); tick();
    chk("R10 second edge", bus_rdata, 32'h0);
    tick();
    chk("R10 third edge", bus_rdata, 32'h5);
    @(negedge clk);

    // R1 mid-run reset
    rst = 1'b1;
    tick(); tick();
    rst = 1'b0;
    @(negedge clk);
    rd(8'h00, q); chk("R1", q, 32'h0);
    rd(8'h80, q); chk("R1", q, 32'h0);
    chk("R1", pad_out, 32'h0);
    finish_run();
  end

endmodule